// File: doc/BRIEF.md
# I/Q Burst Data Path Controller

This block is the baseband end of a parallel radio sample link. On the user side it takes complex transmit samples with a transmit request, and a receive request. Toward the radio it produces a direction level and a framing strobe. It also interleaves I and Q onto one shared sample bus in transmit, and separates the interleaved bus back into I/Q pairs in receive.

The block runs from a single clock at twice the sample rate. Each sample period is two clock cycles, called the first and second half-slot. The double-data-rate pins are modelled as a register-level bus with separate output, output-enable and input ports. The pads, the PLL and the delay centring sit outside the block.

User inputs are sampled once per sample period, on the clock edge that ends the second half-slot (the "tick"). A burst is announced by one strobe period. A second strobe period closes it. The direction level tells the radio which way the samples flow.

Top module: `iqb_datapath`

## Requirements
- R1: `burst_dir` is 1 for a transmit burst and 0 for a receive burst. It changes only at the tick that raises the start strobe, and holds its value until the next start strobe, so it stays valid through the end strobe. It reads 0 after reset.
- R2: `burst_stb` changes only at ticks. It is high for exactly one sample period (two clock cycles) to open a burst, and again for one period to close it, with at least one low period in between. Both strobes appear two sample periods after the tick that decided the start or the end.
- R3: A transmit sample taken at tick T goes out on `iq_out` during the sample period after tick T+3. I is in the first half-slot (`half_ph`=0) and Q is in the second (`half_ph`=1).
- R4: Transmit samples are taken only at ticks where `tx_req` is high and a transmit burst is open or starting. At any other tick the `tx_i`/`tx_q` values are ignored, and the matching bus period has `iq_oe`=0 and `iq_out`=0.
- R5: `iq_oe` is high only while `iq_out` carries a taken transmit sample. Otherwise the bus is released and `iq_out` reads 0.
- R6: On receive, the `iq_in` value held in the first half-slot is taken as I and the value in the second half-slot as Q. The pair from the period that ends at tick C is presented together on `rx_i`/`rx_q` at tick C+5.
- R7: `rx_valid` is high at tick T+8 for each tick T at which a receive burst is open (start tick included, end tick excluded). The first valid pair therefore appears 8 sample periods after the start. `rx_i`/`rx_q` read 0 whenever `rx_valid` is low.
- R8: From idle, a start happens at a tick where a request is high. Transmit wins if both requests are high. An open burst ends at a tick where its own request is low. No start or end is decided at the tick right after another one. A request in the other direction is ignored while a burst is open.
- R9: `half_ph` reads 0 in reset and in the first half-slot, and 1 in the second half-slot. It toggles every clock. The sample width is the parameter `SMP_W` (10 or 12).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| tx_req | input | 1 | Transmit request, sampled at ticks |
| tx_i | input | SMP_W | Transmit I sample |
| tx_q | input | SMP_W | Transmit Q sample |
| rx_req | input | 1 | Receive request, sampled at ticks |
| burst_dir | output | 1 | Burst direction, 1 = transmit |
| burst_stb | output | 1 | Start/end framing strobe |
| iq_out | output | SMP_W | Shared bus drive value |
| iq_oe | output | 1 | Shared bus drive enable |
| iq_in | input | SMP_W | Shared bus value from the radio |
| rx_i | output | SMP_W | Received I word |
| rx_q | output | SMP_W | Received Q word |
| rx_valid | output | 1 | Received pair valid |
| half_ph | output | 1 | Current half-slot, 1 = second |

## Verification
The bench drives several request patterns:
- A plain transmit burst and a plain receive burst. These separate the two strobe latencies, the data offsets and the I-first slot order.
- Both requests raised together, followed by a transmit drop while receive is held. This shows the priority and the guard before the receive start.
- A transmit request raised during an open receive burst. Any reaction to it would show up as a stray strobe or direction change.
- A one-period transmit request and a request that dips low at the guard tick. These exercise the minimum strobe spacing and the ignored-sample periods inside a burst.

The bus input changes every half-slot, so swapped or misaligned receive halves give wrong pairs.

// File: rtl/iqb_pkg.sv
package iqb_pkg;

  typedef enum logic [1:0] {
    BST_IDLE = 2'd0,
    BST_TX   = 2'd1,
    BST_RX   = 2'd2
  } bst_state_e;

  // framing event travelling toward the strobe output
  typedef struct packed {
    logic vld;
    logic is_start;
    logic is_tx;
  } bst_evt_t;

endpackage

// File: rtl/iqb_phase.sv
module iqb_phase (
  input  logic clk,
  input  logic rst,
  output logic ph,
  output logic tick
);

  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end

  // the edge that ends the second half-slot
  assign tick = ph;

endmodule

// File: rtl/iqb_burst_ctl.sv
module iqb_burst_ctl
  import iqb_pkg::*;
#(
  parameter int START_LAT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic tx_req,
  input  logic rx_req,
  output logic tx_take,
  output logic rx_act,
  output logic stb,
  output logic dir
);

  localparam int LAST = START_LAT - 1;

  bst_state_e state, state_nxt;
  logic       guard;
  logic       start_tx, start_rx, stop;
  bst_evt_t   evq [START_LAT];
  bst_evt_t   evt_new;

  always_comb begin
    start_tx  = 1'b0;
    start_rx  = 1'b0;
    stop      = 1'b0;
    state_nxt = state;
    if (!guard) begin
      unique case (state)
        BST_IDLE: begin
          if (tx_req)      start_tx = 1'b1;
          else if (rx_req) start_rx = 1'b1;
        end
        BST_TX:  stop = ~tx_req;
        BST_RX:  stop = ~rx_req;
        default: stop = 1'b1;
      endcase
    end
    if (start_tx)      state_nxt = BST_TX;
    else if (start_rx) state_nxt = BST_RX;
    else if (stop)     state_nxt = BST_IDLE;

    evt_new.vld      = start_tx | start_rx | stop;
    evt_new.is_start = start_tx | start_rx;
    evt_new.is_tx    = start_tx | (stop && state == BST_TX);
  end

  assign tx_take = tx_req && (state_nxt == BST_TX);
  assign rx_act  = (state_nxt == BST_RX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= BST_IDLE;
      guard <= 1'b0;
      stb   <= 1'b0;
      dir   <= 1'b0;
      for (int s = 0; s < START_LAT; s++) evq[s] <= '0;
    end else if (tick) begin
      state  <= state_nxt;
      guard  <= evt_new.vld;
      evq[0] <= evt_new;
      for (int s = 1; s < START_LAT; s++) evq[s] <= evq[s-1];
      stb <= evq[LAST].vld;
      if (evq[LAST].vld && evq[LAST].is_start) dir <= evq[LAST].is_tx;
    end
  end

endmodule

// File: rtl/iqb_tx_mux.sv
module iqb_tx_mux #(
  parameter int W     = 12,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         take,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] in_q,
  output logic [W-1:0] bus_out,
  output logic         bus_oe
);

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] v_pipe;
  logic [W-1:0]     i_pipe [DEPTH];
  logic [W-1:0]     q_pipe [DEPTH];
  logic [W-1:0]     q_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_pipe  <= '0;
      q_hold  <= '0;
      bus_out <= '0;
      bus_oe  <= 1'b0;
      for (int s = 0; s < DEPTH; s++) begin
        i_pipe[s] <= '0;
        q_pipe[s] <= '0;
      end
    end else if (tick) begin
      v_pipe    <= {v_pipe[DEPTH-2:0], take};
      i_pipe[0] <= take ? in_i : '0;
      q_pipe[0] <= take ? in_q : '0;
      for (int s = 1; s < DEPTH; s++) begin
        i_pipe[s] <= i_pipe[s-1];
        q_pipe[s] <= q_pipe[s-1];
      end
      bus_out <= i_pipe[LAST];
      q_hold  <= q_pipe[LAST];
      bus_oe  <= v_pipe[LAST];
    end else begin
      bus_out <= q_hold;
    end
  end

endmodule

// File: rtl/iqb_rx_split.sv
module iqb_rx_split #(
  parameter int W      = 12,
  parameter int FLAG_D = 8,
  parameter int DATA_D = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         act,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] out_i,
  output logic [W-1:0] out_q,
  output logic         out_v
);

  logic [FLAG_D-1:0] f_pipe;
  logic [W-1:0]      i_hold;
  logic [W-1:0]      di [DATA_D];
  logic [W-1:0]      dq [DATA_D];

  always_ff @(posedge clk) begin
    if (rst) begin
      f_pipe <= '0;
      i_hold <= '0;
      out_i  <= '0;
      out_q  <= '0;
      out_v  <= 1'b0;
      for (int s = 0; s < DATA_D; s++) begin
        di[s] <= '0;
        dq[s] <= '0;
      end
    end else if (!tick) begin
      i_hold <= bus_in;
    end else begin
      f_pipe <= {f_pipe[FLAG_D-2:0], act};
      di[0]  <= i_hold;
      dq[0]  <= bus_in;
      for (int s = 1; s < DATA_D; s++) begin
        di[s] <= di[s-1];
        dq[s] <= dq[s-1];
      end
      out_v <= f_pipe[FLAG_D-1];
      out_i <= f_pipe[FLAG_D-1] ? di[DATA_D-1] : '0;
      out_q <= f_pipe[FLAG_D-1] ? dq[DATA_D-1] : '0;
    end
  end

endmodule

// File: rtl/iqb_datapath.sv
module iqb_datapath #(
  parameter int SMP_W     = 12,
  parameter int START_LAT = 2,
  parameter int RX_LAT    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_req,
  input  logic [SMP_W-1:0] tx_i,
  input  logic [SMP_W-1:0] tx_q,
  input  logic             rx_req,
  output logic             burst_dir,
  output logic             burst_stb,
  output logic [SMP_W-1:0] iq_out,
  output logic             iq_oe,
  input  logic [SMP_W-1:0] iq_in,
  output logic [SMP_W-1:0] rx_i,
  output logic [SMP_W-1:0] rx_q,
  output logic             rx_valid,
  output logic             half_ph
);

  // data follows the start strobe by one period
  localparam int TX_DEPTH  = START_LAT + 1;
  localparam int RX_DATA_D = RX_LAT - START_LAT - 1;

  logic tick;
  logic tx_take;
  logic rx_act;

  iqb_phase u_phase (
    .clk  (clk),
    .rst  (rst),
    .ph   (half_ph),
    .tick (tick)
  );

  iqb_burst_ctl #(.START_LAT(START_LAT)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .tx_req  (tx_req),
    .rx_req  (rx_req),
    .tx_take (tx_take),
    .rx_act  (rx_act),
    .stb     (burst_stb),
    .dir     (burst_dir)
  );

  iqb_tx_mux #(.W(SMP_W), .DEPTH(TX_DEPTH)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .take    (tx_take),
    .in_i    (tx_i),
    .in_q    (tx_q),
    .bus_out (iq_out),
    .bus_oe  (iq_oe)
  );

  iqb_rx_split #(.W(SMP_W), .FLAG_D(RX_LAT), .DATA_D(RX_DATA_D)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .act    (rx_act),
    .bus_in (iq_in),
    .out_i  (rx_i),
    .out_q  (rx_q),
    .out_v  (rx_valid)
  );

endmodule

// File: rtl/iqb_datapath_chk.sv
module iqb_datapath_chk #(
  parameter int SMP_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             burst_dir,
  input logic             burst_stb,
  input logic             iq_oe,
  input logic [SMP_W-1:0] rx_i,
  input logic [SMP_W-1:0] rx_q,
  input logic             rx_valid,
  input logic             half_ph
);

  // R2: strobe never lasts more than one sample period
  p_stb_max_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(burst_stb) && $past(burst_stb, 2)) |-> !burst_stb);

  // R2: strobe never shorter than one sample period
  p_stb_min_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(burst_stb) |-> $past(burst_stb, 2));

  // R2: strobe moves only at ticks
  p_stb_slot_r2: assert property (@(posedge clk) disable iff (rst)
    half_ph |-> $stable(burst_stb));

  // R1: direction changes only together with a strobe
  p_dir_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !burst_stb |-> $stable(burst_dir));

  // R5: bus driven only inside a transmit burst
  p_oe_dir_r5: assert property (@(posedge clk) disable iff (rst)
    iq_oe |-> burst_dir);

  // R5: drive enable spans whole sample periods
  p_oe_slot_r5: assert property (@(posedge clk) disable iff (rst)
    half_ph |-> $stable(iq_oe));

  // R7: receive words are zero outside valid pairs
  p_rx_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> (rx_i == '0 && rx_q == '0));

endmodule

bind iqb_datapath iqb_datapath_chk #(.SMP_W(SMP_W)) u_chk (.*);

// File: tb/iqb_datapath_bench.sv
module iqb_datapath_bench;

  localparam int W  = 12;
  localparam int NT = 1024;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tx_req = 1'b0, rx_req = 1'b0;
  logic [W-1:0] tx_i = '0, tx_q = '0, iq_in = '0;
  logic         burst_dir, burst_stb, iq_oe, rx_valid, half_ph;
  logic [W-1:0] iq_out, rx_i, rx_q;

  always #10 clk = ~clk;

  iqb_datapath #(.SMP_W(W)) u_iqb_datapath (
    .clk(clk), .rst(rst), .tx_req(tx_req), .tx_i(tx_i), .tx_q(tx_q),
    .rx_req(rx_req), .burst_dir(burst_dir), .burst_stb(burst_stb),
    .iq_out(iq_out), .iq_oe(iq_oe), .iq_in(iq_in), .rx_i(rx_i),
    .rx_q(rx_q), .rx_valid(rx_valid), .half_ph(half_ph)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string scen = "";

  // expectation schedule, indexed by tick number
  bit        e_stb [NT];
  int        e_dir [NT];   // 0 none, 1 set transmit, 2 set receive
  bit        e_oe  [NT];
  bit [W-1:0] e_ti [NT], e_tq [NT];
  bit        e_rv  [NT];
  bit [W-1:0] e_ri [NT], e_rq [NT];

  int  mode = 0;           // 0 idle, 1 transmit, 2 receive
  int  last_chg = -10;
  int  k = 0;
  int unsigned seed = 32'h1234_5678;
  bit [W-1:0] prev_in = '0;
  // currently expected outputs
  bit        c_stb = 0, c_dir = 0, c_oe = 0, c_rv = 0;
  bit [W-1:0] c_ti = 0, c_tq = 0, c_ri = 0, c_rq = 0;

  function automatic bit [W-1:0] nextval();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[27:16];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s%s at edge %0d: actual %0h expected %0h", tag, scen, k, act, exp);
    end
  endtask

  // behavioural model of one tick decision (R8 rules)
  task automatic model_tick(input int t, input bit txe, input bit rxe,
                            input bit [W-1:0] ti, input bit [W-1:0] tq,
                            input bit [W-1:0] in_first, input bit [W-1:0] in_second);
    bit can = (t - last_chg) >= 2;
    bit evt = 0, is_start = 0;
    int newmode = mode;
    if (can) begin
      if (mode == 0 && txe)             begin newmode = 1; evt = 1; is_start = 1; end
      else if (mode == 0 && rxe)        begin newmode = 2; evt = 1; is_start = 1; end
      else if (mode == 1 && !txe)       begin newmode = 0; evt = 1; end
      else if (mode == 2 && !rxe)       begin newmode = 0; evt = 1; end
    end
    if (evt) begin
      e_stb[t+2] = 1;
      if (is_start) e_dir[t+2] = (newmode == 1) ? 1 : 2;
      last_chg = t;
    end
    if (txe && newmode == 1) begin
      e_oe[t+3] = 1; e_ti[t+3] = ti; e_tq[t+3] = tq;
    end
    if (newmode == 2) e_rv[t+8] = 1;
    e_ri[t+5] = in_first;
    e_rq[t+5] = in_second;
    mode = newmode;
  endtask

  task automatic compare_edge();
    chk("R9 half_ph", half_ph, k % 2);
    if (k % 2 == 0) begin
      int t = k / 2;
      c_stb = e_stb[t];
      if (e_dir[t] == 1) c_dir = 1;
      if (e_dir[t] == 2) c_dir = 0;
      c_oe = e_oe[t]; c_ti = e_ti[t]; c_tq = e_tq[t];
      c_rv = e_rv[t];
      c_ri = c_rv ? e_ri[t] : '0;
      c_rq = c_rv ? e_rq[t] : '0;
    end
    chk("R2 burst_stb", burst_stb, c_stb);
    chk("R1 burst_dir", burst_dir, c_dir);
    chk("R5 iq_oe", iq_oe, c_oe);
    if (c_oe) chk("R3 iq_out", iq_out, (k % 2 == 0) ? c_ti : c_tq);
    else      chk("R5 iq_out released", iq_out, 0);
    chk("R7 rx_valid", rx_valid, c_rv);
    chk("R6 rx_i", rx_i, c_ri);
    chk("R6 rx_q", rx_q, c_rq);
  endtask

  // one sample period: first half-slot edge, then tick edge
  task automatic period(input bit txe, input bit rxe);
    bit [W-1:0] ti, tq, inb;
    iq_in = nextval();
    prev_in = iq_in;
    @(posedge clk); k++;
    @(negedge clk); compare_edge();
    ti = nextval(); tq = nextval(); inb = nextval();
    tx_req = txe; rx_req = rxe; tx_i = ti; tx_q = tq; iq_in = inb;
    model_tick((k + 1) / 2, txe, rxe, ti, tq, prev_in, inb);
    @(posedge clk); k++;
    @(negedge clk); compare_edge();
  endtask

  task automatic run(input int n, input bit txe, input bit rxe);
    for (int i = 0; i < n; i++) period(txe, rxe);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // reset state: R1 R2 R5 R7 R9
    chk("R2 reset burst_stb", burst_stb, 0);
    chk("R1 reset burst_dir", burst_dir, 0);
    chk("R5 reset iq_oe", iq_oe, 0);
    chk("R7 reset rx_valid", rx_valid, 0);
    chk("R9 reset half_ph", half_ph, 0);
    rst = 1'b0;

    run(4, 0, 0);
    run(10, 1, 0);              // plain transmit burst, R3
    run(8, 0, 0);
    run(14, 0, 1);              // plain receive burst, R6 R7
    run(12, 0, 0);

    scen = " R8";
    run(6, 1, 1);               // both: transmit wins
    run(14, 0, 1);              // transmit ends, receive follows guard
    run(3, 1, 1);               // transmit ignored during receive
    run(4, 0, 1);
    run(12, 0, 0);

    scen = " R4";
    run(1, 1, 0);               // start
    run(1, 0, 0);               // guard tick: sample ignored, no end
    run(1, 1, 0);
    run(1, 0, 0);               // end
    run(10, 0, 0);
    run(1, 0, 1);               // one-period receive request
    run(12, 0, 0);
    scen = "";

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule